// File: doc/BRIEF.md
# Hard-Limited Costas Carrier Recovery Loop

This block pulls a suppressed carrier out of a stream of real IF samples, one sample per clock. A numerically controlled oscillator runs near a programmable center frequency. Its cosine and sine outputs multiply each input sample to form an in-phase arm and a quadrature arm. Each arm is smoothed by a short moving average that removes the double-frequency product and leaves a baseband estimate.

The two baseband values feed a polarity-type phase detector. Each arm is multiplied by the sign of the other arm, which only needs a conditional negation. The detector output passes through a proportional-plus-integral filter whose two gains are runtime-selected powers of two. The filter output is added to the center-frequency word, so the loop tracks a frequency deviation introduced by the channel. A lock flag reports when the in-phase magnitude has stayed ahead of the quadrature magnitude by a set margin for a fixed run of samples.

The smoothed I and Q samples leave the block for later stages, such as phase extraction and bit decisions, which are outside this block.

Top module: `costas_carrier_loop`

## Requirements
- R1: While `rstN` is low, `iRec` and `qRec` read 0 and `locked` reads 0. The phase accumulator, the products, the averager histories and the integrator all clear.
- R2: The oscillator phase is a 32-bit accumulator that wraps. On every clock it adds `centerWord + freqAdj` modulo 2^32, where freqAdj is the loop-filter output formed from the current registered state. The top 10 phase bits form address a. Quadrant a[9:8] and index a[7:0] read a 256-entry quarter-wave table T[k] = floor(2047*4p / (1310720 - p)) with p = u*(1024-u) and u = 2k+1. Quadrants 1 and 3 read T[255-index], and quadrants 2 and 3 negate the result. The cosine is the sine at address a+256 mod 1024.
- R3: On each clock the I product register takes sample*cos and the Q product register takes sample*sin, each 24 bits signed. The arm value is the product arithmetically shifted right by 11 and fits in ±2047.
- R4: Each arm keeps a running sum of its last 8 arm values, taken from the product register, in an 8-deep history. `iRec`/`qRec` equal that sum arithmetically shifted right by 3. After 10 consecutive zero input samples both outputs are 0.
- R5: The phase error is e = sgn(iRec)*qRec - sgn(qRec)*iRec, with sgn(v) = +1 for v >= 0 and -1 for v < 0. Each sign product is a conditional negation.
- R6: The error, scaled by 2^16, is arithmetically shifted right by `propShift` to give the proportional term and by `integShift` to give the integrator step. freqAdj is the proportional term plus the integrator value held before the update.
- R7: The integrator saturates at -2^31 and 2^31-1 instead of wrapping.
- R8: A qualifying sample has |iRec| - |qRec| > `lockMargin`, with the margin unsigned. A counter counts consecutive qualifying samples and saturates at 256. `locked` is high exactly when the count is 256, and one non-qualifying sample clears the count.
- R9: With zero input the error is 0, so the oscillator advances at the center frequency alone and both outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one input sample per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 12 | Signed real IF sample |
| centerWord | input | 32 | Oscillator center-frequency increment |
| propShift | input | 5 | Right-shift setting the proportional gain |
| integShift | input | 5 | Right-shift setting the integral gain |
| lockMargin | input | 13 | Unsigned margin by which abs(I) must exceed abs(Q) |
| iRec | output | 13 | Smoothed signed in-phase baseband sample |
| qRec | output | 13 | Smoothed signed quadrature baseband sample |
| locked | output | 1 | Lock indicator |

## Verification
The bench builds the block with its default parameters: a 12-bit sample, a 12-bit table amplitude, a 10-bit table address, an 8-sample average, a 256-sample lock run and a 2^16 error scale. With these values the bench's cycle model can compute the table and the loop arithmetic exactly in plain integers. Shift settings of 0 drive the integrator into its limits within a few samples. Settings of 31 make the loop nearly passive, so a DC input holds the phase still long enough to cross the 256-sample lock run and then lose lock when the margin is raised.

// File: rtl/costas_pkg.sv
`timescale 1ns/1ps
package costas_pkg;
  localparam int unsigned PHASE_W = 32;

  // control -> datapath: per-cycle oscillator steering
  typedef struct packed {
    logic [PHASE_W-1:0] freqAdj;
  } loopCmd_t;
endpackage

// File: rtl/costas_sine_rom.sv
`timescale 1ns/1ps
module costas_sine_rom #(
  parameter int ADDR_W = 10,
  parameter int SIN_W  = 12
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [SIN_W-1:0] sinVal,
  output logic signed [SIN_W-1:0] cosVal
);
  localparam int QN   = 2 ** (ADDR_W - 2);
  localparam int HALF = 4 * QN;
  localparam longint AMP = (longint'(1) <<< (SIN_W - 1)) - 1;

  // rational sine approximation sampled at odd half-steps of a quarter wave
  function automatic longint quarterVal(input longint k);
    longint u, p;
    u = 2 * k + 1;
    p = u * (HALF - u);
    return (AMP * 4 * p) / ((5 * HALF * HALF) / 4 - p);
  endfunction

  logic signed [SIN_W-1:0] tbl [QN];
  for (genvar k = 0; k < QN; k++) begin : g_tbl
    assign tbl[k] = SIN_W'(quarterVal(longint'(k)));
  end

  logic [ADDR_W-1:0] cosAddr;
  logic [ADDR_W-3:0] sIdx, cIdx;
  assign cosAddr = addr + ADDR_W'(QN);

  always_comb begin
    sIdx = addr[ADDR_W-2] ? ~addr[ADDR_W-3:0] : addr[ADDR_W-3:0];
    cIdx = cosAddr[ADDR_W-2] ? ~cosAddr[ADDR_W-3:0] : cosAddr[ADDR_W-3:0];
    sinVal = addr[ADDR_W-1] ? -tbl[sIdx] : tbl[sIdx];
    cosVal = cosAddr[ADDR_W-1] ? -tbl[cIdx] : tbl[cIdx];
  end
endmodule

// File: rtl/costas_movavg.sv
`timescale 1ns/1ps
module costas_movavg #(
  parameter int IN_W    = 13,
  parameter int LOG_LEN = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic signed [IN_W-1:0] armIn,
  output logic signed [IN_W-1:0] avgOut
);
  localparam int LEN   = 2 ** LOG_LEN;
  localparam int SUM_W = IN_W + LOG_LEN;

  logic signed [IN_W-1:0]  hist [LEN];
  logic signed [SUM_W-1:0] runSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runSum <= '0;
      for (int i = 0; i < LEN; i++) hist[i] <= '0;
    end else begin
      runSum  <= runSum + SUM_W'(armIn) - SUM_W'(hist[LEN-1]);
      hist[0] <= armIn;
      for (int i = 1; i < LEN; i++) hist[i] <= hist[i-1];
    end
  end

  assign avgOut = IN_W'(runSum >>> LOG_LEN);
endmodule

// File: rtl/costas_datapath.sv
`timescale 1ns/1ps
module costas_datapath
  import costas_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int SIN_W   = 12,
  parameter int ADDR_W  = 10,
  parameter int AVG_LOG = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [PHASE_W-1:0]       centerWord,
  input  loopCmd_t                 cmd,
  output logic signed [DATA_W:0]   iRec,
  output logic signed [DATA_W:0]   qRec
);
  localparam int PROD_W = DATA_W + SIN_W;
  localparam int REC_W  = DATA_W + 1;

  logic [PHASE_W-1:0]      phaseAcc;
  logic signed [SIN_W-1:0] sinVal, cosVal;
  logic signed [SIN_W-1:0] loVal  [2];
  logic signed [REC_W-1:0] recArr [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseAcc <= '0;
    else       phaseAcc <= phaseAcc + centerWord + cmd.freqAdj;
  end

  costas_sine_rom #(.ADDR_W(ADDR_W), .SIN_W(SIN_W)) i_rom (
    .addr  (phaseAcc[PHASE_W-1 -: ADDR_W]),
    .sinVal(sinVal),
    .cosVal(cosVal)
  );

  assign loVal[0] = cosVal;
  assign loVal[1] = sinVal;

  for (genvar a = 0; a < 2; a++) begin : g_arm
    logic signed [PROD_W-1:0] prodReg;
    logic signed [PROD_W-1:0] prodShr;
    logic signed [REC_W-1:0]  armVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prodReg <= '0;
      else       prodReg <= PROD_W'(sampleIn) * PROD_W'(loVal[a]);
    end

    assign prodShr = prodReg >>> (SIN_W - 1);
    assign armVal  = prodShr[REC_W-1:0];

    costas_movavg #(.IN_W(REC_W), .LOG_LEN(AVG_LOG)) i_avg (
      .clk   (clk),
      .rstN  (rstN),
      .armIn (armVal),
      .avgOut(recArr[a])
    );
  end

  assign iRec = recArr[0];
  assign qRec = recArr[1];
endmodule

// File: rtl/costas_ctrl.sv
`timescale 1ns/1ps
module costas_ctrl
  import costas_pkg::*;
#(
  parameter int REC_W    = 13,
  parameter int SHIFT_W  = 5,
  parameter int LOCK_LEN = 256,
  parameter int ERR_LSH  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [REC_W-1:0] iRec,
  input  logic signed [REC_W-1:0] qRec,
  input  logic [SHIFT_W-1:0]      propShift,
  input  logic [SHIFT_W-1:0]      integShift,
  input  logic [REC_W-1:0]        lockMargin,
  output loopCmd_t                cmd,
  output logic                    locked
);
  localparam int ERR_W = REC_W + 2;
  localparam int CNT_W = $clog2(LOCK_LEN + 1);

  logic signed [ERR_W-1:0]   iExt, qExt, iSigned, qSigned, errVal;
  logic signed [PHASE_W-1:0] errScaled, propTerm, integStep, integReg;
  logic signed [PHASE_W:0]   integSum;
  logic signed [PHASE_W-1:0] integNext;
  logic [CNT_W-1:0]          lockCnt;
  logic signed [ERR_W-1:0]   absI, absQ, marginExt;
  logic                      lockHit;

  // polarity detector: each arm negated by the sign of the other
  always_comb begin
    iExt    = ERR_W'(iRec);
    qExt    = ERR_W'(qRec);
    qSigned = iRec[REC_W-1] ? -qExt : qExt;
    iSigned = qRec[REC_W-1] ? -iExt : iExt;
    errVal  = qSigned - iSigned;
  end

  assign errScaled = PHASE_W'(errVal) <<< ERR_LSH;
  assign propTerm  = errScaled >>> propShift;
  assign integStep = errScaled >>> integShift;
  assign integSum  = (PHASE_W+1)'(integReg) + (PHASE_W+1)'(integStep);

  always_comb begin
    if (integSum[PHASE_W] != integSum[PHASE_W-1])
      integNext = integSum[PHASE_W] ? {1'b1, {(PHASE_W-1){1'b0}}}
                                    : {1'b0, {(PHASE_W-1){1'b1}}};
    else
      integNext = integSum[PHASE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) integReg <= '0;
    else       integReg <= integNext;
  end

  assign cmd.freqAdj = propTerm + integReg;

  // lock qualification
  always_comb begin
    absI      = iExt[ERR_W-1] ? -iExt : iExt;
    absQ      = qExt[ERR_W-1] ? -qExt : qExt;
    marginExt = ERR_W'({2'b00, lockMargin});
    lockHit   = (absI - absQ) > marginExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            lockCnt <= '0;
    else if (!lockHit)                    lockCnt <= '0;
    else if (lockCnt != CNT_W'(LOCK_LEN)) lockCnt <= lockCnt + 1'b1;
  end

  assign locked = (lockCnt == CNT_W'(LOCK_LEN));
endmodule

// File: rtl/costas_carrier_loop.sv
`timescale 1ns/1ps
module costas_carrier_loop
  import costas_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SIN_W    = 12,
  parameter int ADDR_W   = 10,
  parameter int AVG_LOG  = 3,
  parameter int SHIFT_W  = 5,
  parameter int LOCK_LEN = 256,
  parameter int ERR_LSH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [PHASE_W-1:0]       centerWord,
  input  logic [SHIFT_W-1:0]       propShift,
  input  logic [SHIFT_W-1:0]       integShift,
  input  logic [DATA_W:0]          lockMargin,
  output logic signed [DATA_W:0]   iRec,
  output logic signed [DATA_W:0]   qRec,
  output logic                     locked
);
  localparam int REC_W = DATA_W + 1;

  loopCmd_t loopCmd;

  costas_datapath #(
    .DATA_W(DATA_W), .SIN_W(SIN_W), .ADDR_W(ADDR_W), .AVG_LOG(AVG_LOG)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .centerWord(centerWord),
    .cmd       (loopCmd),
    .iRec      (iRec),
    .qRec      (qRec)
  );

  costas_ctrl #(
    .REC_W(REC_W), .SHIFT_W(SHIFT_W), .LOCK_LEN(LOCK_LEN), .ERR_LSH(ERR_LSH)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .iRec      (iRec),
    .qRec      (qRec),
    .propShift (propShift),
    .integShift(integShift),
    .lockMargin(lockMargin),
    .cmd       (loopCmd),
    .locked    (locked)
  );
endmodule

// File: rtl/costas_loop_checker.sv
`timescale 1ns/1ps
module costas_loop_checker #(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic signed [DATA_W-1:0] sampleIn,
  input logic signed [DATA_W:0]   iRec,
  input logic signed [DATA_W:0]   qRec,
  input logic [DATA_W:0]          lockMargin,
  input logic                     locked
);
  localparam int W = DATA_W + 3;
  localparam logic signed [DATA_W:0] REC_MAX = (DATA_W+1)'((1 <<< (DATA_W-1)) - 1);
  localparam logic signed [DATA_W:0] REC_MIN = -REC_MAX;

  logic signed [W-1:0] aI, aQ, mg;
  logic                qual;
  logic [3:0]          zeroRun;

  always_comb begin
    aI   = iRec[DATA_W] ? -W'(iRec) : W'(iRec);
    aQ   = qRec[DATA_W] ? -W'(qRec) : W'(qRec);
    mg   = W'({2'b00, lockMargin});
    qual = (aI - aQ) > mg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              zeroRun <= '0;
    else if (sampleIn != 0) zeroRun <= '0;
    else if (zeroRun != 4'd15) zeroRun <= zeroRun + 1'b1;
  end

  AST_LOCK_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> $past(qual)); // R8
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !qual) |=> !locked); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && qual) |=> locked); // R8
  AST_ZERO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (zeroRun >= 4'd10) |-> (iRec == 0 && qRec == 0)); // R4
  AST_REC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (iRec >= REC_MIN && iRec <= REC_MAX && qRec >= REC_MIN && qRec <= REC_MAX)); // R3
endmodule

bind costas_carrier_loop costas_loop_checker #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleIn  (sampleIn),
  .iRec      (iRec),
  .qRec      (qRec),
  .lockMargin(lockMargin),
  .locked    (locked)
);

// File: tb/test_costas_carrier_loop.sv
`timescale 1ns/1ps
module test_costas_carrier_loop;
  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic signed [11:0] sampleIn = '0;
  logic [31:0]        centerWord = '0;
  logic [4:0]         propShift = 5'd31;
  logic [4:0]         integShift = 5'd31;
  logic [12:0]        lockMargin = '0;
  logic signed [12:0] iRec, qRec;
  logic               locked;

  costas_carrier_loop i_costas_carrier_loop (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .centerWord(centerWord),
    .propShift(propShift), .integShift(integShift), .lockMargin(lockMargin),
    .iRec(iRec), .qRec(qRec), .locked(locked)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  typedef struct {
    int    eI;
    int    eQ;
    bit    eL;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  // ---------------- reference model state (from the requirements) ------------
  bit [31:0] mPh;
  int mProd[2];
  int mHist[2][8];
  int mSum[2];
  longint mInteg;
  int mCnt;

  function automatic longint quarterT(input int k);
    longint u, p;
    u = 2 * k + 1;
    p = u * (1024 - u);
    return (2047 * 4 * p) / (1310720 - p);
  endfunction

  function automatic int sineAt(input int a);
    int idx;
    longint v;
    idx = a & 255;
    if (a & 256) idx = 255 - idx;
    v = quarterT(idx);
    return (a & 512) ? -int'(v) : int'(v);
  endfunction

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic modelReset();
    mPh = '0; mInteg = 0; mCnt = 0;
    for (int a = 0; a < 2; a++) begin
      mProd[a] = 0; mSum[a] = 0;
      for (int j = 0; j < 8; j++) mHist[a][j] = 0;
    end
  endtask

  task automatic modelStep(input int x, input string tag);
    int ri, rq, e, addr, sv, cv, arm;
    longint el, prop, step, s;
    expItem_t it;
    ri = mSum[0] >>> 3;
    rq = mSum[1] >>> 3;
    // R5 error, R6 filter
    e  = ((ri >= 0) ? rq : -rq) - ((rq >= 0) ? ri : -ri);
    el = longint'(e) * 65536;
    prop = el >>> propShift;
    step = el >>> integShift;
    s = mInteg + step;
    if (s > 64'sd2147483647) s = 64'sd2147483647;       // R7
    if (s < -64'sd2147483648) s = -64'sd2147483648;
    // lock (R8)
    if ((iabs(ri) - iabs(rq)) > int'(lockMargin)) mCnt = (mCnt < 256) ? mCnt + 1 : 256;
    else mCnt = 0;
    // oscillator lookup on current phase (R2)
    addr = int'(mPh[31:22]);
    sv = sineAt(addr);
    cv = sineAt((addr + 256) & 1023);
    // averagers take arm from current product (R3, R4)
    for (int a = 0; a < 2; a++) begin
      arm = mProd[a] >>> 11;
      mSum[a] = mSum[a] + arm - mHist[a][7];
      for (int j = 7; j > 0; j--) mHist[a][j] = mHist[a][j-1];
      mHist[a][0] = arm;
    end
    mProd[0] = x * cv;
    mProd[1] = x * sv;
    mPh = mPh + centerWord + 32'(prop) + 32'(mInteg);
    mInteg = s;
    it.eI = mSum[0] >>> 3;
    it.eQ = mSum[1] >>> 3;
    it.eL = (mCnt == 256);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // driver: one sample per call, starting at a falling edge
  task automatic tick(input int x, input string tag);
    sampleIn = 12'(x);
    modelStep(x, tag);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: pop one expected item per edge and compare
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(iRec == it.eI, {it.tag, " iRec"}, int'(iRec), it.eI);
        check(qRec == it.eQ, {it.tag, " qRec"}, int'(qRec), it.eQ);
        check(locked == it.eL, {it.tag, " locked"}, int'(locked), int'(it.eL));
      end
    end
  end

  task automatic resetCheck(input string tag);
    @(negedge clk);
    rstN = 1'b0;
    sampleIn = 12'sd1000;
    modelReset();
    repeat (3) @(negedge clk);
    check(iRec == 0, {tag, " R1 iRec in reset"}, int'(iRec), 0);
    check(qRec == 0, {tag, " R1 qRec in reset"}, int'(qRec), 0);
    check(locked == 0, {tag, " R1 locked in reset"}, int'(locked), 0);
    rstN = 1'b1;
  endtask

  bit [31:0] carPh;
  function automatic int carrier(input bit [31:0] ph, input real amp);
    return $rtoi(amp * $cos(6.283185307179586 * real'(ph) / 4294967296.0));
  endfunction

  initial begin
    modelReset();
    repeat (2) @(negedge clk);
    resetCheck("start");

    // R9: zero input, oscillator free-runs at the center word
    centerWord = 32'h1000_0000; propShift = 5'd31; integShift = 5'd31;
    for (int n = 0; n < 40; n++) tick(0, "R9 zero input");

    // R2 R3 R4: carrier at the center frequency, weak loop
    propShift = 5'd20; integShift = 5'd28; carPh = '0;
    for (int n = 0; n < 400; n++) begin
      tick(carrier(carPh, 1800.0), "R2 R3 R4 carrier on center");
      carPh += 32'h1000_0000;
    end

    // R5 R6: offset carrier, moderate gains
    propShift = 5'd14; integShift = 5'd22;
    for (int n = 0; n < 600; n++) begin
      tick(carrier(carPh, 1700.0), "R5 R6 offset carrier");
      carPh += 32'h1040_0000;
    end

    // R7: unity gains drive the integrator to its limits
    propShift = 5'd0; integShift = 5'd0;
    for (int n = 0; n < 300; n++) begin
      tick(carrier(carPh, 1800.0), "R7 integrator saturation");
      carPh += 32'h0C00_0000;
    end
    for (int n = 0; n < 20; n++) tick(0, "R4 R7 flush after saturation");

    // R8: DC input, quiet loop, lock and loss of lock
    resetCheck("relock");
    centerWord = '0; propShift = 5'd31; integShift = 5'd31; lockMargin = 13'd100;
    for (int n = 0; n < 400; n++) tick(1500, "R8 lock build-up");
    check(locked == 1'b1, "R8 lock after long qualifying run", int'(locked), 1);
    lockMargin = 13'd4000;
    tick(1500, "R8 margin raised");
    tick(1500, "R8 margin raised");
    check(locked == 1'b0, "R8 lock cleared by margin", int'(locked), 0);
    lockMargin = 13'd100;
    for (int n = 0; n < 30; n++) tick(0, "R4 R8 zero after lock");
    check(iRec == 0 && qRec == 0, "R4 outputs flushed to zero", int'(iRec), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule